// File: doc/BRIEF.md
# Timer Count-Enable Source Selector

This block decides when a timer/counter is allowed to advance. A shared, free-running binary divider counts system clock cycles. A 3-bit source code picks what drives the timer's count-enable. The timer can be halted. It can advance on every clock. It can advance once per period of one of four divider taps. It can also advance on the falling or rising transitions of an external pin, which is first synchronized to the system clock. The result is a single-cycle strobe, registered and synchronous to the system clock, that the counter uses as its clock enable.

The pin is sampled as a plain level, whatever is driving it. If the same pad is driven as an output, software can toggle it to step the counter. A separate clear input zeroes the shared divider, so software can line up the prescaled taps with an event.

Top module: `tcs_clock_select`

## Requirements
- R1: With source code 000 the count-enable stays low, so the timer is halted.
- R2: With source code 001 the count-enable is high in every cycle that follows a clock edge at which code 001 was applied, giving division by 1.
- R3: Codes 010, 011, 100 and 101 select divider taps with shift widths SH_A, SH_B, SH_C and SH_D (defaults 3, 6, 8 and 10, giving division by 8, 64, 256 and 1024). For a selected tap of width S, the enable is high for one cycle exactly when the low S bits of the divider have just wrapped from all ones to zero.
- R4: Code 111 counts rising transitions of the external pin and code 110 counts falling ones. The pin is synchronized by two flops. A change of pin level sampled at clock edge j produces exactly one enable, high in the cycle after edge j+2.
- R5: When the clear input is high at a clock edge, the divider becomes zero, so each tap's next pulse comes 2^S cycles after that edge.
- R6: A new source code takes effect from the next clock edge. The pin edge detector runs under every code, so switching to a pin code yields a pulse only for a pin transition that really occurred in the detection window.
- R7: While reset is asserted the count-enable is low. After reset the divider starts from zero and the synchronizer holds low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 3 | Count source code |
| ext_pin | input | 1 | External count pin, asynchronous to clk |
| pre_clr | input | 1 | Clears the shared divider to zero |
| count_en | output | 1 | Single-cycle count-enable strobe |

## Verification
The bench builds the block with a 6-bit divider and tap widths 1, 2, 4 and 6. Every tap period, up to 64 cycles, therefore repeats several times within a short run, and the full wrap of the divider is exercised. Each of the eight codes is swept with varied pin patterns and a divider clear. A long pseudo-random phase then switches codes, toggles the pin (including every-cycle toggles) and clears the divider at random. The bench predicts every single cycle's enable from a plain arithmetic count of clock edges and a three-edge delay of the pin history.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

    localparam int TCS_NUM_TAPS = 4;

    typedef enum logic [2:0] {
        SRC_OFF      = 3'd0,
        SRC_DIV1     = 3'd1,
        SRC_TAP_A    = 3'd2,
        SRC_TAP_B    = 3'd3,
        SRC_TAP_C    = 3'd4,
        SRC_TAP_D    = 3'd5,
        SRC_PIN_FALL = 3'd6,
        SRC_PIN_RISE = 3'd7
    } tcs_src_e;

    typedef struct packed {
        logic meta;
        logic stable;
        logic prev;
    } tcs_sync_t;

endpackage

// File: rtl/tcs_divider.sv
module tcs_divider #(
    parameter int DIV_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic [DIV_W-1:0] div_q
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_state_t;

    div_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign div_q = st_q.cnt;

endmodule

// File: rtl/tcs_tap_hits.sv
module tcs_tap_hits
    import tcs_pkg::*;
#(
    parameter int DIV_W = 10,
    parameter int SH_A  = 3,
    parameter int SH_B  = 6,
    parameter int SH_C  = 8,
    parameter int SH_D  = 10
) (
    input  logic [DIV_W-1:0]        div,
    output logic [TCS_NUM_TAPS-1:0] wrap
);

    function automatic int tap_shift(input int t);
        case (t)
            0:       return SH_A;
            1:       return SH_B;
            2:       return SH_C;
            default: return SH_D;
        endcase
    endfunction

    // A tap wraps on the edge at which its low bits leave the all-ones state.
    for (genvar t = 0; t < TCS_NUM_TAPS; t++) begin : g_tap
        localparam int SH = tap_shift(t);
        assign wrap[t] = &div[SH-1:0];
    end

endmodule

// File: rtl/tcs_pin_edge.sv
module tcs_pin_edge
    import tcs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);

    tcs_sync_t sy_d, sy_q;

    always_comb begin
        sy_d        = sy_q;
        sy_d.meta   = pin;
        sy_d.stable = sy_q.meta;
        sy_d.prev   = sy_q.stable;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sy_q <= '0;
        end else begin
            sy_q <= sy_d;
        end
    end

    assign rise = sy_q.stable & ~sy_q.prev;
    assign fall = ~sy_q.stable & sy_q.prev;

endmodule

// File: rtl/tcs_clock_select.sv
module tcs_clock_select
    import tcs_pkg::*;
#(
    parameter int DIV_W = 10,
    parameter int SH_A  = 3,
    parameter int SH_B  = 6,
    parameter int SH_C  = 8,
    parameter int SH_D  = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] sel,
    input  logic       ext_pin,
    input  logic       pre_clr,
    output logic       count_en
);

    typedef struct packed {
        logic en;
    } out_state_t;

    logic [DIV_W-1:0]        div_q;
    logic [TCS_NUM_TAPS-1:0] tap_wrap;
    logic                    pin_rise;
    logic                    pin_fall;
    tcs_src_e                src;
    out_state_t              out_d, out_q;

    tcs_divider #(
        .DIV_W (DIV_W)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (pre_clr),
        .div_q (div_q)
    );

    tcs_tap_hits #(
        .DIV_W (DIV_W),
        .SH_A  (SH_A),
        .SH_B  (SH_B),
        .SH_C  (SH_C),
        .SH_D  (SH_D)
    ) u_taps (
        .div  (div_q),
        .wrap (tap_wrap)
    );

    tcs_pin_edge u_pin (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (ext_pin),
        .rise  (pin_rise),
        .fall  (pin_fall)
    );

    assign src = tcs_src_e'(sel);

    always_comb begin
        out_d = out_q;
        case (src)
            SRC_OFF:      out_d.en = 1'b0;
            SRC_DIV1:     out_d.en = 1'b1;
            SRC_TAP_A:    out_d.en = tap_wrap[0];
            SRC_TAP_B:    out_d.en = tap_wrap[1];
            SRC_TAP_C:    out_d.en = tap_wrap[2];
            SRC_TAP_D:    out_d.en = tap_wrap[3];
            SRC_PIN_FALL: out_d.en = pin_fall;
            SRC_PIN_RISE: out_d.en = pin_rise;
            default:      out_d.en = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign count_en = out_q.en;

endmodule

// File: rtl/tcs_clock_select_chk.sv
module tcs_clock_select_chk #(
    parameter int DIV_W = 10,
    parameter int SH_A  = 3,
    parameter int SH_B  = 6,
    parameter int SH_C  = 8,
    parameter int SH_D  = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       sel,
    input logic             pre_clr,
    input logic             count_en,
    input logic [DIV_W-1:0] div_q
);

    function automatic logic [DIV_W-1:0] low_mask(input logic [2:0] s);
        int sh;
        case (s)
            3'd2:    sh = SH_A;
            3'd3:    sh = SH_B;
            3'd4:    sh = SH_C;
            3'd5:    sh = SH_D;
            default: sh = 0;
        endcase
        return DIV_W'((32'd1 << sh) - 32'd1);
    endfunction

    // R1
    a_r1_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 3'd0) |=> !count_en);

    // R2
    a_r2_every_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 3'd1) |=> count_en);

    // R3
    a_r3_tap_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (count_en && $past(sel) >= 3'd2 && $past(sel) <= 3'd5)
        |-> ((div_q & low_mask($past(sel))) == '0));

    // R4
    a_r4_pin_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (count_en && sel[2:1] == 2'b11 && $past(sel) == sel) |=> !count_en);

    // R5
    a_r5_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        pre_clr |=> (div_q == '0));

endmodule

bind tcs_clock_select tcs_clock_select_chk #(
    .DIV_W (DIV_W),
    .SH_A  (SH_A),
    .SH_B  (SH_B),
    .SH_C  (SH_C),
    .SH_D  (SH_D)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (sel),
    .pre_clr  (pre_clr),
    .count_en (count_en),
    .div_q    (div_q)
);

// File: tb/sim_tcs_clock_select.sv
module sim_tcs_clock_select;

    localparam int DW = 6;
    localparam int SA = 1;
    localparam int SB = 2;
    localparam int SC = 4;
    localparam int SD = 6;
    localparam int LIMIT = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] sel = 3'd0;
    logic       ext_pin = 1'b0;
    logic       pre_clr = 1'b0;
    logic       count_en;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // Bench model: divider value and pin levels sampled at the last three edges.
    int m = 0;
    bit h1 = 1'b0, h2 = 1'b0, h3 = 1'b0;

    tcs_clock_select #(
        .DIV_W (DW),
        .SH_A  (SA),
        .SH_B  (SB),
        .SH_C  (SC),
        .SH_D  (SD)
    ) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (sel),
        .ext_pin  (ext_pin),
        .pre_clr  (pre_clr),
        .count_en (count_en)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        forever begin
            @(posedge clk);
            if (cyc > LIMIT) begin
                errors++;
                $display("FAIL watchdog: run hung at cycle %0d (expected end before %0d)", cyc, LIMIT);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    function automatic int shift_of(input logic [2:0] s);
        case (s)
            3'd2:    return SA;
            3'd3:    return SB;
            3'd4:    return SC;
            default: return SD;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] s);
        case (s)
            3'd0:    return "R1";
            3'd1:    return "R2";
            3'd6, 3'd7: return "R4";
            default: return "R3";
        endcase
    endfunction

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d sel %0d: count_en=%0b expected %0b",
                     tag, cyc, sel, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic step(input logic [2:0] s, input bit p, input bit c, input string tag);
        logic exp;
        int   mask;
        sel     = s;
        ext_pin = p;
        pre_clr = c;
        case (s)
            3'd0: exp = 1'b0;
            3'd1: exp = 1'b1;
            3'd6: exp = !h2 && h3;
            3'd7: exp = h2 && !h3;
            default: begin
                mask = (1 << shift_of(s)) - 1;
                exp  = ((m & mask) == mask);
            end
        endcase
        @(posedge clk);
        #1;
        check(count_en, exp, tag);
        m  = c ? 0 : (m + 1) % (1 << DW);
        h3 = h2;
        h2 = h1;
        h1 = p;
        @(negedge clk);
    endtask

    initial begin
        logic [15:0] lfsr;
        logic [2:0]  cur;
        // R7: enable held low throughout reset
        repeat (3) @(posedge clk);
        #1;
        check(count_en, 1'b0, "R7");
        @(negedge clk);
        rst_n = 1'b1;

        // Sweep every source code with varied pin patterns and one clear.
        for (int s = 0; s < 8; s++) begin
            for (int i = 0; i < 160; i++) begin
                bit p;
                bit c;
                p = ((i % (3 + s)) < 2) ^ (i % 11 == 0);
                c = (i == 97);
                step(3'(s), p, c, (c && s >= 2 && s <= 5) ? "R5" : tag_of(3'(s)));
            end
        end

        // R6: random code switching, pin activity and clears.
        lfsr = 16'hACE1;
        cur  = 3'd0;
        for (int i = 0; i < 1500; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[5:3] == 3'd0) cur = lfsr[2:0];
            step(cur, (i % 200 < 40) ? (i % 2 == 1) : lfsr[7], lfsr[15:11] == 5'd0, "R6");
        end

        // R7: reset asserted mid-run while every-cycle counting is selected.
        sel   = 3'd1;
        rst_n = 1'b0;
        #1;
        check(count_en, 1'b0, "R7");
        @(posedge clk);
        #1;
        check(count_en, 1'b0, "R7");
        @(negedge clk);
        rst_n = 1'b1;
        m  = 0;
        h1 = 1'b0;
        h2 = 1'b0;
        h3 = 1'b0;
        // R7: after reset the divider restarts from zero (tap A wraps on schedule).
        for (int i = 0; i < 12; i++) step(3'd2, 1'b0, 1'b0, "R7");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule